// File: doc/BRIEF.md
# Triplicated Memory with Majority-Vote Scrubber

This block keeps every data word in three identical synchronous RAM copies, so that an upset in any one copy is outvoted. A user read returns the bitwise two-out-of-three majority of the copies, and a flag marks any read where the copies did not all agree. Each copy has two ports. The user owns the first port. The second port belongs to an internal sweep engine, so the user port is never stalled.

The sweep engine visits one address every two cycles. In the first cycle it reads all three copies. In the second cycle it votes, and only if the copies disagreed it writes the voted word back to all three. The address then moves up by one and wraps from the top address to zero. A full pass over 512 words therefore takes 1024 cycles. The engine drops its write-back when the user has written the same address during the visit, so user data always wins. A saturating counter records each write-back.

For verification, a test tap turns a user write into a write of a single copy, which plants a one-copy error. With default parameters each copy holds 512 words of 8 bits, which is 4 Kbit.

Top module: `tmr_scrub_mem`

## Requirements
- R1: A user write (`usr_en`=1, `usr_we`=1, `tap_en`=0) stores `usr_wdata` in all three copies. A user read (`usr_en`=1, `usr_we`=0) presents the stored word on `usr_rdata` in the cycle after the request. The user port is serviced every cycle, whatever the sweep engine is doing.
- R2: Read data is the per-bit majority of the three copies. `usr_disagree` is 1 in the read-data cycle exactly when the three copies are not all equal, and it is 0 in every cycle that does not follow a read.
- R3: With `tap_en`=1, a user write goes only to the copy numbered by `tap_copy` (0, 1 or 2). With `tap_copy`=3 it writes no copy.
- R4: The sweep engine spends two cycles per address: a fetch cycle, then a mend cycle. Addresses run upward from 0 after reset and wrap from 511 to 0. A word whose copies disagree at its fetch holds the voted value in all three copies after its mend.
- R5: The sweep engine writes back only words whose copies disagreed. Over sweeps of consistent memory, `fixed_count` does not change.
- R6: If a user-port write targets the address being mended in the mend cycle itself, the write-back is dropped, and the user's data remains in all copies.
- R7: If a user-port write targets the address being swept in its fetch cycle, the following mend drops its write-back, so stale voted data never overwrites the new word.
- R8: `fixed_count` rises by exactly one for each write-back and holds at its all-ones value once it gets there. The width is `CNT_W`, default 16.
- R9: After synchronous reset, `fixed_count` is 0 and `usr_disagree` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_en | input | 1 | User port request |
| usr_we | input | 1 | User port write (1) or read (0) |
| usr_addr | input | ADDR_W | User port word address |
| usr_wdata | input | DATA_W | User write data |
| tap_en | input | 1 | Test tap: restrict a write to one copy |
| tap_copy | input | 2 | Copy selected by the test tap (3 = none) |
| usr_rdata | output | DATA_W | Voted read data, one cycle after the read |
| usr_disagree | output | 1 | Copies differed on the read now presented |
| fixed_count | output | CNT_W | Saturating count of sweep write-backs |

## Verification
The bench plants single-copy and two-copy upsets far ahead of the sweep position. It confirms that reads are voted and flagged, and that a later pass repairs them. A design that voted wrongly would return the planted value, and one that skipped repairs would still flag after a full pass. Words at 511 and 0 are planted to catch a sweep that does not wrap. Two long repeating patterns of single-copy corruption and user rewrites of one address line up every phase of the visit against the user write. A design without the same-cycle drop, or without the fetch-cycle guard, bumps the counter or leaves stale data in place. A narrowed counter is driven past its maximum to expose a counter that wraps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 9;
    localparam int CNT_W_DEF  = 16;
    localparam int N_COPIES   = 3;
    localparam int SEL_W      = 2;

    // Two-step visit of the sweep engine per address
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_MEND  = 1'b1
    } sweep_phase_e;

    // Per-bit two-out-of-three vote
    function automatic logic bit_vote(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_ram_copy.sv
module tmr_ram_copy #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              pa_en,
    input  logic              pa_we,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [DATA_W-1:0] pa_wdata,
    output logic [DATA_W-1:0] pa_rdata,
    input  logic              pb_en,
    input  logic              pb_we,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [DATA_W-1:0] pb_wdata,
    output logic [DATA_W-1:0] pb_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Both ports are synchronous; a read that meets a write returns the old word
    always_ff @(posedge clk) begin
        if (pa_en) begin
            if (pa_we) store[pa_addr] <= pa_wdata;
            else       pa_rdata       <= store[pa_addr];
        end
        if (pb_en) begin
            if (pb_we) store[pb_addr] <= pb_wdata;
            else       pb_rdata       <= store[pb_addr];
        end
    end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] w0,
    input  logic [DATA_W-1:0] w1,
    input  logic [DATA_W-1:0] w2,
    output logic [DATA_W-1:0] voted,
    output logic              differ
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign voted[i] = tmr_pkg::bit_vote(w0[i], w1[i], w2[i]);
    end

    assign differ = (w0 != w1) || (w0 != w2);
endmodule

// File: rtl/tmr_sat_counter.sv
module tmr_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                       count <= '0;
        else if (bump && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/tmr_sweeper.sv
module tmr_sweeper #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_wr,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] fetch_voted,
    input  logic              fetch_differ,
    output logic              sw_en,
    output logic              sw_we,
    output logic [ADDR_W-1:0] sw_addr,
    output logic [DATA_W-1:0] sw_wdata,
    output logic              mend_pulse
);
    import tmr_pkg::*;

    sweep_phase_e      phase;
    logic [ADDR_W-1:0] cursor;
    logic              touched_in_fetch;
    logic              touched_now;
    logic              mend_go;

    assign touched_now = usr_wr && (usr_addr == cursor);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase            <= PH_FETCH;
            cursor           <= '0;
            touched_in_fetch <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    phase            <= PH_MEND;
                    touched_in_fetch <= touched_now;
                end
                default: begin
                    phase            <= PH_FETCH;
                    cursor           <= cursor + 1'b1;
                    touched_in_fetch <= 1'b0;
                end
            endcase
        end
    end

    // Write back only a disagreeing word that the user has not touched during the visit
    always_comb begin
        mend_go    = (phase == PH_MEND) && fetch_differ && !touched_in_fetch && !touched_now;
        sw_addr    = cursor;
        sw_wdata   = fetch_voted;
        sw_we      = mend_go;
        sw_en      = (phase == PH_FETCH) || mend_go;
        mend_pulse = mend_go;
    end
endmodule

// File: rtl/tmr_scrub_mem.sv
module tmr_scrub_mem #(
    parameter int DATA_W = tmr_pkg::DATA_W_DEF,
    parameter int ADDR_W = tmr_pkg::ADDR_W_DEF,
    parameter int CNT_W  = tmr_pkg::CNT_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     usr_en,
    input  logic                     usr_we,
    input  logic [ADDR_W-1:0]        usr_addr,
    input  logic [DATA_W-1:0]        usr_wdata,
    input  logic                     tap_en,
    input  logic [tmr_pkg::SEL_W-1:0] tap_copy,
    output logic [DATA_W-1:0]        usr_rdata,
    output logic                     usr_disagree,
    output logic [CNT_W-1:0]         fixed_count
);
    import tmr_pkg::*;

    logic [DATA_W-1:0] a_q [N_COPIES];
    logic [DATA_W-1:0] b_q [N_COPIES];
    logic [DATA_W-1:0] a_voted;
    logic              a_differ;
    logic [DATA_W-1:0] b_voted;
    logic              b_differ;
    logic              usr_wr;
    logic              rd_pend;
    logic              scr_en;
    logic              scr_we;
    logic [ADDR_W-1:0] scr_addr;
    logic [DATA_W-1:0] scr_wdata;
    logic              scr_mend;

    assign usr_wr = usr_en && usr_we;

    for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
        logic copy_we;
        assign copy_we = usr_we && (!tap_en || tap_copy == SEL_W'(k));

        tmr_ram_copy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
            .clk      (clk),
            .pa_en    (usr_en && (copy_we || !usr_we)),
            .pa_we    (copy_we),
            .pa_addr  (usr_addr),
            .pa_wdata (usr_wdata),
            .pa_rdata (a_q[k]),
            .pb_en    (scr_en),
            .pb_we    (scr_we),
            .pb_addr  (scr_addr),
            .pb_wdata (scr_wdata),
            .pb_rdata (b_q[k])
        );
    end

    tmr_voter #(.DATA_W(DATA_W)) u_vote_usr (
        .w0 (a_q[0]), .w1 (a_q[1]), .w2 (a_q[2]),
        .voted (a_voted), .differ (a_differ)
    );

    tmr_voter #(.DATA_W(DATA_W)) u_vote_sweep (
        .w0 (b_q[0]), .w1 (b_q[1]), .w2 (b_q[2]),
        .voted (b_voted), .differ (b_differ)
    );

    tmr_sweeper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sweep (
        .clk          (clk),
        .rst          (rst),
        .usr_wr       (usr_wr),
        .usr_addr     (usr_addr),
        .fetch_voted  (b_voted),
        .fetch_differ (b_differ),
        .sw_en        (scr_en),
        .sw_we        (scr_we),
        .sw_addr      (scr_addr),
        .sw_wdata     (scr_wdata),
        .mend_pulse   (scr_mend)
    );

    tmr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .bump  (scr_mend),
        .count (fixed_count)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_pend <= 1'b0;
        else     rd_pend <= usr_en && !usr_we;
    end

    assign usr_rdata    = a_voted;
    assign usr_disagree = rd_pend && a_differ;
endmodule

// File: rtl/tmr_scrub_mem_chk.sv
module tmr_scrub_mem_chk #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              usr_en,
    input logic              usr_we,
    input logic [ADDR_W-1:0] usr_addr,
    input logic              usr_disagree,
    input logic [CNT_W-1:0]  fixed_count,
    input logic              scr_we,
    input logic [ADDR_W-1:0] scr_addr
);
    localparam logic [CNT_W-1:0] FULL = '1;

    assert_flag_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
        usr_disagree |-> $past(usr_en && !usr_we));

    assert_walk_upward_R4: assert property (@(posedge clk) disable iff (rst)
        (scr_addr != $past(scr_addr)) |-> (scr_addr == ADDR_W'($past(scr_addr) + 1'b1)));

    assert_mend_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        scr_we |=> !scr_we);

    assert_count_from_mend_R5: assert property (@(posedge clk) disable iff (rst)
        (fixed_count != $past(fixed_count)) |-> $past(scr_we));

    assert_no_clash_R6: assert property (@(posedge clk) disable iff (rst)
        scr_we |-> !(usr_en && usr_we && usr_addr == scr_addr));

    assert_fetch_guard_R7: assert property (@(posedge clk) disable iff (rst)
        scr_we |-> !$past(usr_en && usr_we && usr_addr == scr_addr));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (fixed_count != $past(fixed_count)) |-> (fixed_count == CNT_W'($past(fixed_count) + 1'b1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(fixed_count) == FULL) |-> (fixed_count == FULL));
endmodule

bind tmr_scrub_mem tmr_scrub_mem_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .usr_en       (usr_en),
    .usr_we       (usr_we),
    .usr_addr     (usr_addr),
    .usr_disagree (usr_disagree),
    .fixed_count  (fixed_count),
    .scr_we       (scr_we),
    .scr_addr     (scr_addr)
);

// File: tb/sim_tmr_scrub_mem.sv
`timescale 1ns/1ps
module sim_tmr_scrub_mem;
    localparam int DW    = 8;
    localparam int AW    = 9;
    localparam int CW    = 4;
    localparam int DEPTH = 512;
    localparam int SWEEP = 2 * DEPTH;
    localparam int CMAX  = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          usr_en = 1'b0;
    logic          usr_we = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic          tap_en = 1'b0;
    logic [1:0]    tap_copy = 2'd0;
    logic [DW-1:0] usr_rdata;
    logic          usr_disagree;
    logic [CW-1:0] fixed_count;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    tmr_scrub_mem #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk (clk), .rst (rst),
        .usr_en (usr_en), .usr_we (usr_we), .usr_addr (usr_addr), .usr_wdata (usr_wdata),
        .tap_en (tap_en), .tap_copy (tap_copy),
        .usr_rdata (usr_rdata), .usr_disagree (usr_disagree), .fixed_count (fixed_count)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic int fill_val(input int a);
        return (a * 7 + 3) & 255;
    endfunction

    function automatic int maj(input int a, input int b, input int c);
        return ((a & b) | (a & c) | (b & c)) & 255;
    endfunction

    function automatic int sweep_pos();
        return (cyc / 2) % DEPTH;
    endfunction

    function automatic int far_addr(input int off);
        return (sweep_pos() + 256 + off) % DEPTH;
    endfunction

    function automatic int cap(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d, input bit tap, input int copy);
        usr_en = 1'b1; usr_we = 1'b1;
        usr_addr = AW'(a); usr_wdata = DW'(d);
        tap_en = tap; tap_copy = 2'(copy);
        @(negedge clk);
        usr_en = 1'b0; usr_we = 1'b0; tap_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d, output int f);
        usr_en = 1'b1; usr_we = 1'b0; usr_addr = AW'(a);
        @(negedge clk);
        usr_en = 1'b0;
        d = int'(usr_rdata);
        f = int'(usr_disagree);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R9", "count after reset", int'(fixed_count), 0);
        chk("R9", "flag after reset", int'(usr_disagree), 0);
        rst = 1'b0;
        idle(1);
        chk("R2", "flag with no read", int'(usr_disagree), 0);
    endtask

    task automatic t_fill_and_clean();
        int d, f;
        for (int a = 0; a < DEPTH; a++) wr(a, fill_val(a), 1'b0, 0);
        idle(SWEEP + 64);
        exp_cnt = int'(fixed_count);
        idle(SWEEP + 64);
        chk("R5", "count over clean sweep", int'(fixed_count), exp_cnt);
        for (int a = 5; a < DEPTH; a += 101) begin
            rd(a, d, f);
            chk("R1", "fill readback", d, fill_val(a));
            chk("R2", "flag on clean word", f, 0);
        end
    endtask

    task automatic t_user_rw();
        int d, f;
        int a0 = far_addr(0);
        int a1 = far_addr(1);
        wr(a0, 8'h5A, 1'b0, 0);
        wr(a1, 8'hC3, 1'b0, 0);
        rd(a0, d, f);
        chk("R1", "write then read", d, 8'h5A);
        rd(a1, d, f);
        chk("R1", "second word", d, 8'hC3);
        chk("R2", "flag after full write", f, 0);
    endtask

    task automatic t_upsets();
        int d, f;
        int b = far_addr(10);
        int orig [5];
        for (int k = 0; k < 5; k++) begin
            orig[k] = (8'h11 * (k + 1)) & 255;
            wr((b + k) % DEPTH, orig[k], 1'b0, 0);
        end
        for (int k = 0; k < 3; k++) begin
            wr((b + k) % DEPTH, orig[k] ^ 8'hA5, 1'b1, k);
            rd((b + k) % DEPTH, d, f);
            chk("R3", "single-copy upset outvoted", d, orig[k]);
            chk("R2", "single-copy upset flagged", f, 1);
        end
        wr((b + 3) % DEPTH, 8'hEE, 1'b1, 3);
        rd((b + 3) % DEPTH, d, f);
        chk("R3", "tap copy 3 writes nothing", d, orig[3]);
        chk("R3", "tap copy 3 leaves no flag", f, 0);
        wr((b + 4) % DEPTH, 8'hF0, 1'b1, 0);
        wr((b + 4) % DEPTH, 8'h3C, 1'b1, 1);
        rd((b + 4) % DEPTH, d, f);
        chk("R2", "bitwise vote of three values", d, maj(8'hF0, 8'h3C, orig[4]));
        chk("R2", "three-way difference flagged", f, 1);
        idle(SWEEP + 64);
        exp_cnt = cap(exp_cnt + 4);
        for (int k = 0; k < 5; k++) begin
            rd((b + k) % DEPTH, d, f);
            chk("R4", "word after sweep", d, (k == 4) ? maj(8'hF0, 8'h3C, orig[4]) : orig[k]);
            chk("R4", "no flag after sweep", f, 0);
        end
        chk("R8", "one count per repaired word", int'(fixed_count), exp_cnt);
    endtask

    task automatic t_wrap();
        int d, f;
        while (!(sweep_pos() >= 128 && sweep_pos() < 384)) idle(1);
        wr(511, 8'h81, 1'b0, 0);
        wr(0, 8'h42, 1'b0, 0);
        wr(511, 8'h7E, 1'b1, 2);
        wr(0, 8'hBD, 1'b1, 1);
        rd(511, d, f);
        chk("R2", "top word upset flagged", f, 1);
        rd(0, d, f);
        chk("R2", "word 0 upset flagged", f, 1);
        idle(SWEEP + 64);
        exp_cnt = cap(exp_cnt + 2);
        rd(511, d, f);
        chk("R4", "top word repaired", d, 8'h81);
        chk("R4", "top word clean", f, 0);
        rd(0, d, f);
        chk("R4", "word 0 repaired after wrap", d, 8'h42);
        chk("R4", "word 0 clean", f, 0);
        chk("R8", "count after wrap repairs", int'(fixed_count), exp_cnt);
    endtask

    // Pattern A: corrupt, rewrite, idle. Pattern B: corrupt, idle, rewrite.
    task automatic t_collide(input bit pat_b, input string req);
        int d, f;
        int x = 100;
        int cur = 8'h20;
        wr(x, cur, 1'b0, 0);
        for (int i = 0; i < SWEEP; i++) begin
            wr(x, (~cur) & 255, 1'b1, 0);
            if (pat_b) idle(1);
            cur = (cur + 1) & 255;
            wr(x, cur, 1'b0, 0);
            if (!pat_b) idle(1);
        end
        idle(4);
        rd(x, d, f);
        chk(req, "user data survives visit", d, cur);
        chk(req, "word consistent", f, 0);
        chk(req, "no write-back counted", int'(fixed_count), exp_cnt);
    endtask

    task automatic t_saturate();
        int d, f;
        int b = far_addr(40);
        for (int k = 0; k < 20; k++) wr((b + k) % DEPTH, 8'h90 + k, 1'b0, 0);
        for (int k = 0; k < 20; k++) wr((b + k) % DEPTH, (~(8'h90 + k)) & 255, 1'b1, 1);
        idle(SWEEP + 64);
        chk("R8", "count holds at maximum", int'(fixed_count), CMAX);
        rd((b + 19) % DEPTH, d, f);
        chk("R4", "last planted word repaired", d, 8'h90 + 19);
    endtask

    initial begin
        idle(4);
        t_reset();
        t_fill_and_clean();
        t_user_rw();
        t_upsets();
        t_wrap();
        t_collide(1'b0, "R7");
        t_collide(1'b1, "R6");
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule